// File: doc/BRIEF.md
# Interleaved Thread Issue Scheduler

This block sits at the front of a fine-grained multithreaded in-order core with a two-level pipeline. It holds a program counter and a state for each hardware thread. Every cycle it picks one thread to issue, and it never picks a thread that already has an instruction in the pipeline. Because a thread never occupies two pipeline stages at once, the core needs no operand forwarding, no branch predictor and no flush. Each thread's next PC comes from the resolved result that its own instruction returns at writeback.

A thread whose instruction was a load, a store or a fetch request is parked when it reaches writeback. It stays parked until the background transfer unit reports completion for it. An external per-thread hold mask can also keep a ready thread from being picked. When nothing is eligible, the block leaves a bubble. At reset only thread 0 runs, from PC 0. Each other thread is switched on through a start port that supplies its first PC.

Top module: `interleave_issue_sched`

## Requirements
- R1: While `rst` is high, `issue_valid` is 0. After reset, thread 0 is ready at PC 0 and all other threads are idle, so the first issue is thread 0 at PC 0.
- R2: An issued thread is in flight and is not issued again until its writeback arrives. At most one instruction per thread is in flight at any time.
- R3: A writeback with `wb_to_bg`=0 for an in-flight thread loads `wb_next_pc` into that thread's PC. The thread can then issue from the next cycle on.
- R4: A writeback with `wb_to_bg`=1 for an in-flight thread loads its PC and parks the thread. The thread is not issued until `bg_done_valid` names it. After that it issues from the PC that was loaded at writeback.
- R5: Among the eligible threads, the pick is round-robin. The search starts at the thread after the last issued one and wraps from N-1 to 0. The last-issued pointer only moves on a valid issue, and it starts at N-1 after reset.
- R6: When no thread is eligible, `issue_valid` is 0, and `issue_tid` and `issue_pc` are both 0.
- R7: `start_valid` on an idle thread sets its PC to `start_pc` and makes it ready. On a thread that is not idle, `start_valid` has no effect.
- R8: A thread whose `hold_mask` bit is 1 is not issued in that cycle. Its state and PC are kept.
- R9: A writeback for a thread that is not in flight, or a completion for a thread that is not parked, has no effect.
- R10: A start, a writeback and a completion that name different threads in the same cycle all take effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start request for an idle thread |
| start_tid | input | TID_W | Thread to start |
| start_pc | input | PC_W | First PC of the started thread |
| hold_mask | input | NUM_THREADS | Per-thread external block, 1 = do not issue |
| wb_valid | input | 1 | Writeback of an in-flight instruction |
| wb_tid | input | TID_W | Thread of the writeback |
| wb_to_bg | input | 1 | Instruction was handed to the background unit |
| wb_next_pc | input | PC_W | Resolved next PC of that thread |
| bg_done_valid | input | 1 | Background unit finished a request |
| bg_done_tid | input | TID_W | Thread whose request finished |
| issue_valid | output | 1 | A thread is issued this cycle |
| issue_tid | output | TID_W | Issued thread, 0 when none |
| issue_pc | output | PC_W | PC of the issued thread, 0 when none |

## Verification
A writeback that returns one thread and a completion that releases another can land in the same cycle. Either of them can also coincide with the pick of a third thread. The bench provokes this by parking every thread, then releasing them one by one while the writebacks of other threads keep flowing. A long pseudo-random phase with random holds, starts and stray events follows. A cycle-level model built from the requirements predicts every pick, PC and bubble, and any disagreement in the same cycle is reported.

// File: rtl/its_pkg.sv
package its_pkg;

    typedef enum logic [1:0] {
        THR_IDLE      = 2'd0,
        THR_READY     = 2'd1,
        THR_IN_FLIGHT = 2'd2,
        THR_WAIT_BG   = 2'd3
    } thr_state_e;

    // A thread is a candidate only when it is ready and not held externally.
    function automatic logic thr_eligible(input thr_state_e st, input logic hold);
        return (st == THR_READY) && !hold;
    endfunction

    // Each event is legal in exactly one state, so at most one applies.
    function automatic thr_state_e thr_next(
        input thr_state_e st,
        input logic       issue_hit,
        input logic       start_hit,
        input logic       wb_hit,
        input logic       wb_bg,
        input logic       done_hit
    );
        thr_state_e nx;
        nx = st;
        case (st)
            THR_IDLE:      if (start_hit) nx = THR_READY;
            THR_READY:     if (issue_hit) nx = THR_IN_FLIGHT;
            THR_IN_FLIGHT: if (wb_hit)    nx = wb_bg ? THR_WAIT_BG : THR_READY;
            THR_WAIT_BG:   if (done_hit)  nx = THR_READY;
            default:       nx = THR_IDLE;
        endcase
        return nx;
    endfunction

    function automatic logic thr_pc_load(input thr_state_e st, input logic start_hit,
                                         input logic wb_hit);
        return ((st == THR_IDLE) && start_hit) || ((st == THR_IN_FLIGHT) && wb_hit);
    endfunction

endpackage

// File: rtl/its_event_decode.sv
module its_event_decode #(
    parameter int NUM_THREADS = 8,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   evt_valid,
    input  logic [TID_W-1:0]       evt_tid,
    output logic [NUM_THREADS-1:0] evt_hit
);
    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_dec
        assign evt_hit[g] = evt_valid && (evt_tid == TID_W'(g));
    end
endmodule

// File: rtl/its_thread_slot.sv
module its_thread_slot
    import its_pkg::*;
#(
    parameter int   PC_W         = 32,
    parameter logic RESET_ACTIVE = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            issue_hit,
    input  logic            start_hit,
    input  logic [PC_W-1:0] start_pc,
    input  logic            wb_hit,
    input  logic            wb_bg,
    input  logic [PC_W-1:0] wb_pc,
    input  logic            done_hit,
    output logic            eligible,
    output logic [PC_W-1:0] pc
);
    thr_state_e      state_q;
    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RESET_ACTIVE ? THR_READY : THR_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= thr_next(state_q, issue_hit, start_hit, wb_hit, wb_bg, done_hit);
            if (thr_pc_load(state_q, start_hit, wb_hit))
                pc_q <= (state_q == THR_IDLE) ? start_pc : wb_pc;
        end
    end

    assign eligible = thr_eligible(state_q, hold);
    assign pc       = pc_q;

    // R2: a grant only reaches a thread that is ready and not held
    p_issue_legal_r2: assert property (@(posedge clk) disable iff (rst)
        issue_hit |-> (state_q == THR_READY && !hold));

    // R3: writeback of an in-flight thread installs the resolved PC
    p_wb_pc_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == THR_IN_FLIGHT && wb_hit) |=> (pc_q == $past(wb_pc)));

    // R4: a parked thread stays parked until its completion arrives
    p_parked_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == THR_WAIT_BG && !done_hit) |=> (state_q == THR_WAIT_BG));

    // R9: PC changes only through a legal start or writeback
    p_pc_guard_r9: assert property (@(posedge clk) disable iff (rst)
        !((state_q == THR_IDLE && start_hit) || (state_q == THR_IN_FLIGHT && wb_hit))
        |=> $stable(pc_q));

endmodule

// File: rtl/its_rr_arbiter.sv
module its_rr_arbiter #(
    parameter int NUM_THREADS = 8,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_THREADS-1:0] req,
    output logic [NUM_THREADS-1:0] grant,
    output logic [TID_W-1:0]       gnt_idx,
    output logic                   any
);
    logic [TID_W-1:0] last_q;

    always_comb begin
        int idx;
        grant   = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int off = 1; off <= NUM_THREADS; off++) begin
            idx = int'(last_q) + off;
            if (idx >= NUM_THREADS) idx = idx - NUM_THREADS;
            if (!any && req[idx]) begin
                any        = 1'b1;
                grant[idx] = 1'b1;
                gnt_idx    = TID_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      last_q <= TID_W'(NUM_THREADS - 1);
        else if (any) last_q <= gnt_idx;
    end

    // R5: one grant at most, only to a requester, and never idle when one asks
    p_grant_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    p_grant_subset_r5: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);
    p_work_conserving_r6: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> any);

endmodule

// File: rtl/interleave_issue_sched.sv
module interleave_issue_sched
    import its_pkg::*;
#(
    parameter int NUM_THREADS = 8,
    parameter int PC_W        = 32,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_valid,
    input  logic [TID_W-1:0]       start_tid,
    input  logic [PC_W-1:0]        start_pc,
    input  logic [NUM_THREADS-1:0] hold_mask,
    input  logic                   wb_valid,
    input  logic [TID_W-1:0]       wb_tid,
    input  logic                   wb_to_bg,
    input  logic [PC_W-1:0]        wb_next_pc,
    input  logic                   bg_done_valid,
    input  logic [TID_W-1:0]       bg_done_tid,
    output logic                   issue_valid,
    output logic [TID_W-1:0]       issue_tid,
    output logic [PC_W-1:0]        issue_pc
);
    logic [NUM_THREADS-1:0] start_hit, wb_hit, done_hit;
    logic [NUM_THREADS-1:0] elig, grant, grant_q;
    logic [PC_W-1:0]        slot_pc [NUM_THREADS];
    logic [TID_W-1:0]       gnt_idx;
    logic                   any;

    its_event_decode #(.NUM_THREADS(NUM_THREADS)) u_dec_start (
        .evt_valid(start_valid), .evt_tid(start_tid), .evt_hit(start_hit));
    its_event_decode #(.NUM_THREADS(NUM_THREADS)) u_dec_wb (
        .evt_valid(wb_valid), .evt_tid(wb_tid), .evt_hit(wb_hit));
    its_event_decode #(.NUM_THREADS(NUM_THREADS)) u_dec_done (
        .evt_valid(bg_done_valid), .evt_tid(bg_done_tid), .evt_hit(done_hit));

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_slot
        its_thread_slot #(
            .PC_W        (PC_W),
            .RESET_ACTIVE(g == 0)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .hold     (hold_mask[g]),
            .issue_hit(grant_q[g]),
            .start_hit(start_hit[g]),
            .start_pc (start_pc),
            .wb_hit   (wb_hit[g]),
            .wb_bg    (wb_to_bg),
            .wb_pc    (wb_next_pc),
            .done_hit (done_hit[g]),
            .eligible (elig[g]),
            .pc       (slot_pc[g])
        );
    end

    its_rr_arbiter #(.NUM_THREADS(NUM_THREADS)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .req    (elig),
        .grant  (grant),
        .gnt_idx(gnt_idx),
        .any    (any)
    );

    // No issue is committed while reset is held.
    assign grant_q = rst ? '0 : grant;

    always_comb begin
        issue_pc = '0;
        for (int i = 0; i < NUM_THREADS; i++)
            if (grant_q[i]) issue_pc = issue_pc | slot_pc[i];
    end

    assign issue_valid = any && !rst;
    assign issue_tid   = issue_valid ? gnt_idx : '0;

    // R1: nothing issues during reset
    p_quiet_in_reset_r1: assert property (@(posedge clk) rst |-> !issue_valid);

    // R6: a bubble presents zero thread and zero PC
    p_bubble_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> (issue_tid == '0 && issue_pc == '0));

    // R2: the same thread is never issued in two consecutive cycles
    p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> !(issue_valid && issue_tid == $past(issue_tid)));

endmodule

// File: tb/interleave_issue_sched_tb.sv
module interleave_issue_sched_tb;
    localparam int N  = 8;
    localparam int PW = 32;
    localparam int TW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          start_valid = 0, wb_valid = 0, wb_to_bg = 0, bg_done_valid = 0;
    logic [TW-1:0] start_tid = 0, wb_tid = 0, bg_done_tid = 0;
    logic [PW-1:0] start_pc = 0, wb_next_pc = 0;
    logic [N-1:0]  hold_mask = 0;
    logic          issue_valid;
    logic [TW-1:0] issue_tid;
    logic [PW-1:0] issue_pc;

    interleave_issue_sched #(.NUM_THREADS(N), .PC_W(PW)) u_dut (
        .clk(clk), .rst(rst),
        .start_valid(start_valid), .start_tid(start_tid), .start_pc(start_pc),
        .hold_mask(hold_mask),
        .wb_valid(wb_valid), .wb_tid(wb_tid), .wb_to_bg(wb_to_bg), .wb_next_pc(wb_next_pc),
        .bg_done_valid(bg_done_valid), .bg_done_tid(bg_done_tid),
        .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc));

    // model: 0 idle, 1 ready, 2 in flight, 3 parked
    int            mst [N];
    logic [PW-1:0] mpc [N];
    int            mlast;
    bit            pv1, pv2;
    int            pt1, pt2;
    logic [PW-1:0] pp1, pp2;
    int            g_bgmode;
    logic [N-1:0]  g_hold;
    logic [31:0]   rs = 32'h1234_5678;
    int            errors = 0, checks = 0, bubbles = 0;
    bit            done_flag = 0;

    function automatic logic [31:0] rnd();
        rs = rs ^ (rs << 13);
        rs = rs ^ (rs >> 17);
        rs = rs ^ (rs << 5);
        return rs;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit sv = 0, input int stid = 0,
                        input logic [PW-1:0] spc = 0, input bit dv = 0, input int dtid = 0,
                        input bit jv = 0, input int jtid = 0);
        int nst [N];
        bit ev; int et; logic [PW-1:0] ep;
        start_valid = sv; start_tid = TW'(stid); start_pc = spc;
        hold_mask = g_hold;
        bg_done_valid = dv; bg_done_tid = TW'(dtid);
        if (pv2) begin
            wb_valid = 1; wb_tid = TW'(pt2);
            wb_to_bg = (g_bgmode == 1) || (g_bgmode == 2 && rnd()[3]);
            wb_next_pc = rnd()[0] ? rnd() : pp2 + 32'd4;
        end else if (jv) begin
            wb_valid = 1; wb_tid = TW'(jtid); wb_to_bg = rnd()[1]; wb_next_pc = rnd();
        end else begin
            wb_valid = 0; wb_tid = 0; wb_to_bg = 0; wb_next_pc = 0;
        end
        #1;
        ev = 0; et = 0; ep = 0;
        for (int off = 1; off <= N; off++) begin
            int idx;
            idx = (mlast + off) % N;
            if (!ev && mst[idx] == 1 && !g_hold[idx]) begin ev = 1; et = idx; ep = mpc[idx]; end
        end
        chk(tag, {28'd0, issue_valid, issue_tid, issue_pc},
                 {28'd0, ev, TW'(et), ep});
        if (!ev) bubbles++;
        nst = mst;
        if (ev) begin nst[et] = 2; mlast = et; end
        if (wb_valid && mst[wb_tid] == 2) begin
            mpc[wb_tid] = wb_next_pc; nst[wb_tid] = wb_to_bg ? 3 : 1;
        end
        if (dv && mst[dtid] == 3) nst[dtid] = 1;
        if (sv && mst[stid] == 0) begin nst[stid] = 1; mpc[stid] = spc; end
        mst = nst;
        pv2 = pv1; pt2 = pt1; pp2 = pp1;
        pv1 = ev;  pt1 = et;  pp1 = ep;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog R2: actual=timeout expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin mst[i] = (i == 0) ? 1 : 0; mpc[i] = 0; end
        mlast = N - 1; pv1 = 0; pv2 = 0; pt1 = 0; pt2 = 0; pp1 = 0; pp2 = 0;
        g_bgmode = 0; g_hold = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset quiet", {63'd0, issue_valid}, 64'd0);
        rst = 0;

        // R1 first issue, R6 bubbles while thread 0 is in flight, R3 resolved PC
        step("R1");
        step("R6");
        step("R6");
        step("R3");
        step("R3");
        // R7 start threads with their own first PCs
        for (int i = 1; i < N; i++) step("R7", 1, i, 32'h1000 * i);
        for (int i = 0; i < 16; i++) step("R5");
        for (int i = 0; i < 8; i++) step("R2");
        // R7 start on a running thread is ignored
        step("R7", 1, 3, 32'hDEAD0);
        for (int i = 0; i < 12; i++) step("R7");
        // R8 hold masks
        g_hold = 8'h0F;
        for (int i = 0; i < 12; i++) step("R8");
        g_hold = 8'hFF;
        for (int i = 0; i < 6; i++) step("R8");
        g_hold = 8'h00;
        for (int i = 0; i < 4; i++) step("R8");
        // R4 park everyone, release one at a time
        g_bgmode = 1;
        for (int i = 0; i < 12; i++) step("R4");
        for (int i = 0; i < N; i++) begin step("R4", 0, 0, 0, 1, i); step("R4"); end
        g_bgmode = 0;
        for (int i = 0; i < 4; i++) step("R4");
        // R10 completions coinciding with writebacks of other threads
        for (int i = 0; i < N; i++) step("R10", 0, 0, 0, 1, i);
        for (int i = 0; i < 4; i++) step("R10");
        // R9 stray writebacks and completions
        for (int i = 0; i < 24; i++) step("R9", 0, 0, 0, 1, int'(rnd() % N), 1, int'(rnd() % N));
        // R10 pseudo-random mix
        g_bgmode = 2;
        for (int i = 0; i < 4000; i++) begin
            bit sv, dv, jv; int stid, dtid;
            logic [31:0] a;
            sv = (rnd() % 16) == 0; stid = int'(rnd() % N);
            g_hold = N'(rnd() & rnd() & rnd());
            dv = 0; dtid = 0;
            a = rnd();
            for (int k = 0; k < N; k++) begin
                int t;
                t = (int'(a % N) + k) % N;
                if (!dv && mst[t] == 3 && a[8]) begin dv = 1; dtid = t; end
            end
            if (!dv && (rnd() % 8) == 0) begin dv = 1; dtid = int'(rnd() % N); end
            jv = (rnd() % 8) == 0;
            step("R10", sv, stid, rnd(), dv, dtid, jv, int'(rnd() % N));
        end
        g_hold = '0;
        $display("bubbles observed: %0d", bubbles);
        done_flag = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule